// File: doc/BRIEF.md
# Multidrop Serial Transmitter with Address Marker

This block turns parallel bytes into asynchronous serial frames for a shared multidrop line. When the marker mode is on, every frame carries one extra bit that tells listening nodes whether the frame is an address or data. An address frame opens a block of frames for one node. The data frames that follow go to that node. The block starts a new block with its next address frame. The gaps between frames and between blocks may be any length and carry no meaning.

Software writes a byte into a holding buffer and, when it wants an address frame, sets a wake flag. When the serializer is free, it takes the byte and copies the wake flag into its own marker bit. At that moment the wake flag clears itself. Because the byte and the flag are both held apart from the serializer, the next frame and its flag can be written while the current frame is still on the line. A baud tick input runs at eight pulses per bit time. Word length, parity and stop-bit count come from static configuration inputs, which are captured when the serializer takes a byte.

Top module: `mdtx_top`

## Requirements
- R1: After reset `txd`=1, `buf_empty`=1, `shift_empty`=1 and `wake_flag`=0. `txd` is 1 whenever `shift_empty` is 1.
- R2: A frame is sent in this order: a start bit of 0, then `cfg_len`+1 data bits with the least significant bit first (`cfg_len` ranges 0..7), then the marker bit if enabled, then the parity bit if enabled, then the stop bits at 1. The configuration is captured in the transfer cycle.
- R3: Each bit stays on `txd` for exactly 8 `tick` pulses. The start bit appears on the clock after the transfer, and a tick in the transfer cycle is not counted. `shift_empty` rises on the clock of the 8×N-th tick, where N is the number of bits in the frame. Ticks while idle change nothing.
- R4: With `cfg_mark_en`=1 the marker bit equals the wake flag value at transfer: 1 for an address frame, 0 for a data frame. With `cfg_mark_en`=0 no marker bit is inserted.
- R5: `wake_flag` clears to 0 on the clock of the transfer, whatever `cfg_mark_en` is, unless `wr_wake_en` is asserted in that same cycle.
- R6: With `cfg_par_en`=1 the parity bit covers the data bits and the marker bit. With `cfg_par_odd`=0 the total count of ones in those bits plus the parity bit is even. With `cfg_par_odd`=1 that total is odd.
- R7: `cfg_two_stop`=1 sends two stop bits; otherwise one stop bit is sent.
- R8: `buf_empty` falls on the clock after a data write. A transfer happens on the clock after the buffer is full while the serializer is idle, and `buf_empty` rises with it. A byte and wake flag written during a frame leave that frame intact and are sent in the next frame.
- R9: `shift_empty` is 1 exactly when no frame is being shifted and the buffer is empty.
- R10: `txd` changes only on a clock edge that carries a tick or a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Baud tick, 8 per bit time |
| wr_data_en | input | 1 | Write strobe for the data buffer |
| wr_data | input | 8 | Byte to send |
| wr_wake_en | input | 1 | Write strobe for the wake flag |
| wr_wake | input | 1 | Wake flag value; 1 marks the next frame as an address |
| cfg_len | input | 3 | Number of data bits minus one |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_mark_en | input | 1 | Inserts the address marker bit |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer can take a byte |
| shift_empty | output | 1 | Line idle and nothing pending |
| wake_flag | output | 1 | Current wake flag value |

## Verification
On every cycle the assertions check the idle-high line, the start bit that follows each transfer, the self-clearing wake flag, the buffer flag timing and the rule that the line only moves on a tick or a transfer. The frame contents can only be shown by the bench's scenarios: bit order, word length, marker value, parity sense and stop count. The same holds for the exact length of a frame in ticks and for a queued byte and flag reaching the following frame unharmed. A scoreboard decodes each frame from the line at mid-bit and compares it with frames predicted from the configuration.

// File: rtl/mdtx_pkg.sv
package mdtx_pkg;

    // Per-frame options captured when the serializer takes a byte
    typedef struct packed {
        logic par_en;
        logic par_odd;
        logic two_stop;
        logic mark_en;
    } mdtx_cfg_t;

endpackage

// File: rtl/mdtx_hold.sv
module mdtx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_wake_en,
    input  logic          wr_wake,
    input  logic          take,
    output logic [DW-1:0] hold_data,
    output logic          hold_full,
    output logic          hold_wake
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          full;
        logic          wake;
    } hold_t;

    hold_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        // Transfer empties the buffer and self-clears the wake flag
        if (take) begin
            s_d.full = 1'b0;
            s_d.wake = 1'b0;
        end
        // Fresh writes in the same cycle take priority
        if (wr_data_en) begin
            s_d.data = wr_data;
            s_d.full = 1'b1;
        end
        if (wr_wake_en) begin
            s_d.wake = wr_wake;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hold_data = s_q.data;
    assign hold_full = s_q.full;
    assign hold_wake = s_q.wake;

endmodule

// File: rtl/mdtx_shift.sv
module mdtx_shift
    import mdtx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int TPB = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  load,
    input  logic [DW-1:0]         ld_data,
    input  logic                  ld_mark,
    input  logic [$clog2(DW)-1:0] cfg_len,
    input  mdtx_cfg_t             cfg,
    output logic                  busy,
    output logic                  txd
);

    localparam int FRMW = DW + 5;              // start + data + marker + parity + 2 stop
    localparam int PW   = $clog2(FRMW + 1);
    localparam int CNTW = $clog2(TPB);

    typedef struct packed {
        logic [FRMW-1:0] frm;   // remaining bits, LSB on the line
        logic [PW-1:0]   left;  // bits still to finish
        logic [CNTW-1:0] sub;   // ticks spent in the current bit
        logic            busy;
    } shift_t;

    shift_t          s_q, s_d;
    logic [FRMW-1:0] frame_ld;
    logic [PW-1:0]   pos;
    logic            par;

    // Assemble the whole frame at once; unused upper positions stay 1
    always_comb begin
        frame_ld    = '1;
        frame_ld[0] = 1'b0;
        pos         = PW'(1);
        par         = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i <= int'(cfg_len)) begin
                frame_ld[pos] = ld_data[i];
                par           = par ^ ld_data[i];
                pos           = pos + 1'b1;
            end
        end
        if (cfg.mark_en) begin
            frame_ld[pos] = ld_mark;
            par           = par ^ ld_mark;
            pos           = pos + 1'b1;
        end
        if (cfg.par_en) begin
            frame_ld[pos] = par ^ cfg.par_odd;
            pos           = pos + 1'b1;
        end
        pos = pos + 1'b1;
        if (cfg.two_stop) begin
            pos = pos + 1'b1;
        end
    end

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.frm  = frame_ld;
            s_d.left = pos;
            s_d.sub  = '0;
            s_d.busy = 1'b1;
        end else if (s_q.busy && tick) begin
            if (s_q.sub == CNTW'(TPB - 1)) begin
                s_d.sub  = '0;
                s_d.frm  = {1'b1, s_q.frm[FRMW-1:1]};
                s_d.left = s_q.left - 1'b1;
                if (s_q.left == PW'(1)) begin
                    s_d.busy = 1'b0;
                end
            end else begin
                s_d.sub = s_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{frm: '1, left: '0, sub: '0, busy: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = s_q.busy;
    assign txd  = !s_q.busy || s_q.frm[0];

endmodule

// File: rtl/mdtx_top.sv
module mdtx_top
    import mdtx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int TPB = 8,
    localparam int LENW = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            wr_data_en,
    input  logic [DW-1:0]   wr_data,
    input  logic            wr_wake_en,
    input  logic            wr_wake,
    input  logic [LENW-1:0] cfg_len,
    input  logic            cfg_par_en,
    input  logic            cfg_par_odd,
    input  logic            cfg_two_stop,
    input  logic            cfg_mark_en,
    output logic            txd,
    output logic            buf_empty,
    output logic            shift_empty,
    output logic            wake_flag
);

    logic [DW-1:0] hold_data;
    logic          hold_full;
    logic          hold_wake;
    logic          busy;
    logic          take;
    mdtx_cfg_t     cfg;

    assign cfg  = '{par_en: cfg_par_en, par_odd: cfg_par_odd,
                    two_stop: cfg_two_stop, mark_en: cfg_mark_en};
    assign take = hold_full && !busy;

    mdtx_hold #(.DW(DW)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data_en (wr_data_en),
        .wr_data    (wr_data),
        .wr_wake_en (wr_wake_en),
        .wr_wake    (wr_wake),
        .take       (take),
        .hold_data  (hold_data),
        .hold_full  (hold_full),
        .hold_wake  (hold_wake)
    );

    mdtx_shift #(.DW(DW), .TPB(TPB)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (take),
        .ld_data (hold_data),
        .ld_mark (hold_wake),
        .cfg_len (cfg_len),
        .cfg     (cfg),
        .busy    (busy),
        .txd     (txd)
    );

    assign buf_empty   = !hold_full;
    assign shift_empty = !busy && !hold_full;
    assign wake_flag   = hold_wake;

endmodule

// File: rtl/mdtx_chk.sv
module mdtx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic take,
    input logic wr_data_en,
    input logic wr_wake_en,
    input logic txd,
    input logic buf_empty,
    input logic shift_empty,
    input logic wake_flag
);

    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd);

    a_r3_start_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !txd);

    a_r5_wake_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_wake_en) |=> !wake_flag);

    a_r8_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_data_en) |=> buf_empty);

    a_r8_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_en |=> !buf_empty);

    a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !take) |=> $stable(txd));

endmodule

bind mdtx_top mdtx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .take        (take),
    .wr_data_en  (wr_data_en),
    .wr_wake_en  (wr_wake_en),
    .txd         (txd),
    .buf_empty   (buf_empty),
    .shift_empty (shift_empty),
    .wake_flag   (wake_flag)
);

// File: tb/mdtx_top_test.sv
module mdtx_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_data_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_wake_en = 1'b0;
    logic       wr_wake = 1'b0;
    logic [2:0] cfg_len = 3'd7;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_mark_en = 1'b1;
    logic       txd, buf_empty, shift_empty, wake_flag;

    int checks = 0;
    int fails  = 0;
    int tdiv   = 0;

    typedef struct {
        logic [15:0] bits;
        int          n;
    } exp_t;

    exp_t q[$];
    exp_t mon_e;
    int   mon_n;
    int   ticks_seen;

    mdtx_top uut (
        .clk (clk), .rst_n (rst_n), .tick (tick),
        .wr_data_en (wr_data_en), .wr_data (wr_data),
        .wr_wake_en (wr_wake_en), .wr_wake (wr_wake),
        .cfg_len (cfg_len), .cfg_par_en (cfg_par_en), .cfg_par_odd (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop), .cfg_mark_en (cfg_mark_en),
        .txd (txd), .buf_empty (buf_empty), .shift_empty (shift_empty),
        .wake_flag (wake_flag)
    );

    always #5 clk = ~clk;

    // One tick every four clocks, changed on the falling edge
    always @(negedge clk) begin
        tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
        tick <= (tdiv == 3);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic [7:0] d, input logic w);
        exp_t e;
        logic p;
        e.bits = '1;
        e.bits[0] = 1'b0;
        e.n = 1;
        p = 1'b0;
        for (int i = 0; i <= int'(cfg_len); i++) begin
            e.bits[e.n] = d[i];
            p ^= d[i];
            e.n++;
        end
        if (cfg_mark_en) begin
            e.bits[e.n] = w;
            p ^= w;
            e.n++;
        end
        if (cfg_par_en) begin
            e.bits[e.n] = p ^ cfg_par_odd;
            e.n++;
        end
        e.n += cfg_two_stop ? 2 : 1;
        return e;
    endfunction

    // Driver: writes byte and wake flag together, queues the expected frame
    task automatic send(input logic [7:0] d, input logic w);
        @(negedge clk);
        while (!buf_empty) @(negedge clk);
        wr_data = d; wr_data_en = 1'b1;
        wr_wake = w; wr_wake_en = 1'b1;
        q.push_back(predict(d, w));
        @(negedge clk);
        wr_data_en = 1'b0; wr_wake_en = 1'b0;
        check("R8 buf_empty after write", buf_empty, 0);
    endtask

    // Counts ticks from the start bit until the line is idle again
    task automatic measure(input int nbits);
        while (txd !== 1'b0) @(negedge clk);
        ticks_seen = 0;
        do begin
            @(negedge clk);
            if (tick) ticks_seen++;
        end while (!shift_empty);
        check("R3 frame length in ticks", ticks_seen, 8 * nbits);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!shift_empty || q.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    // Monitor: decodes each frame at mid-bit and compares with the queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                if (q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R2 frame with nothing queued actual=1 expected=0");
                    while (!shift_empty) @(negedge clk);
                end else begin
                    mon_e = q.pop_front();
                    mon_n = 0;
                    for (int k = 0; k < mon_e.n; k++) begin
                        while (mon_n != 8 * k + 4) begin
                            @(negedge clk);
                            if (tick) mon_n++;
                        end
                        checks++;
                        if (txd !== mon_e.bits[k]) begin
                            fails++;
                            $display("FAIL R2/R4/R6/R7 frame bit %0d actual=%b expected=%b",
                                     k, txd, mon_e.bits[k]);
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 txd idle", txd, 1);
        check("R1 buf_empty", buf_empty, 1);
        check("R9 shift_empty", shift_empty, 1);
        check("R1 wake_flag", wake_flag, 0);
        rst_n = 1'b1;

        // R3: ticks while idle change nothing
        repeat (40) @(negedge clk);
        check("R3 idle ticks ignored", {txd, shift_empty}, 2'b11);

        // Address frame, 8 bits, marker on, no parity, one stop: 11 bits
        send(8'hA5, 1'b1);
        @(negedge clk);
        check("R5 wake cleared at transfer", wake_flag, 0);
        check("R8 buf_empty at transfer", buf_empty, 1);
        check("R9 shift_empty while shifting", shift_empty, 0);
        measure(11);

        // R6 even parity, R7 two stops, 5 data bits: 10 bits
        cfg_len = 3'd4; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_two_stop = 1'b1;
        send(8'h13, 1'b1);
        measure(10);
        send(8'h0E, 1'b0);
        measure(10);

        // R4 marker off, R6 odd parity: wake still self-clears
        cfg_len = 3'd7; cfg_par_odd = 1'b1; cfg_two_stop = 1'b0; cfg_mark_en = 1'b0;
        send(8'h6B, 1'b1);
        @(negedge clk);
        check("R5 wake cleared with marker off", wake_flag, 0);
        measure(11);

        // R8 double buffering: queued bytes and flags go to the next frames
        cfg_par_odd = 1'b0; cfg_mark_en = 1'b1;
        send(8'h3C, 1'b1);
        send(8'h81, 1'b0);
        check("R9 shift_empty with byte pending", shift_empty, 0);
        send(8'hFF, 1'b1);
        send(8'h00, 1'b0);
        wait_idle();

        // R5/R4: wake written alone mid-frame is held until the next byte
        send(8'h55, 1'b0);
        repeat (20) @(negedge clk);
        wr_wake = 1'b1; wr_wake_en = 1'b1;
        @(negedge clk);
        wr_wake_en = 1'b0;
        check("R5 wake readback mid-frame", wake_flag, 1);
        wait_idle();

        // R2 shortest word: 1 data bit, no marker, no parity: 3 bits
        cfg_len = 3'd0; cfg_par_en = 1'b0; cfg_mark_en = 1'b0;
        send(8'h02, 1'b0);
        measure(3);
        send(8'h01, 1'b0);
        measure(3);
        wait_idle();
        check("R1 line idle at end", txd, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule